// File: doc/BRIEF.md
# Serial-Loaded Eight-Channel Code Register

This block takes 12-bit words from a three-wire serial link (serial clock, serial data, load strobe) and holds eight 8-bit codes, one per converter channel, as parallel outputs. Every word carries an 8-bit code and a 4-bit channel address. A rising edge of the load strobe copies the code into the one channel register that the address names.

Every serial pin is brought into the system clock domain through a synchronizer and then edge-detected. A rising serial clock moves the shift register by one place. A rising load strobe causes exactly one write. The bit at the far end of the shift register is driven on a serial output, so several blocks can be chained on one serial data line.

Top module: `serial_code_bank`

## Requirements
- R1: After reset, all eight channel codes are 0 and the serial output is 0.
- R2: A word is 12 bits and is sent with bit D11 first and bit D0 last. After a load, the addressed channel holds D7..D0, with D0 as the least significant bit.
- R3: The channel address is D8·8 + D9·4 + D10·2 + D11. Values 1 to 8 select channels 1 to 8. A write changes only the selected channel. Channel n appears on `codes[8n-1 -: 8]`.
- R4: Address values 0 and 9 to 15 change no channel.
- R5: One rising edge of the load strobe causes exactly one write. Serial clock edges that arrive while the load strobe is high still shift, and their word is written only on the next rising edge of the load strobe.
- R6: The serial output shows the bit that entered the shift register 12 serial clock edges earlier. After a full word it shows that word's D11.
- R7: Each rising edge of the serial clock shifts exactly one place, however long the clock stays high. Without serial clock edges, the shift register and the serial output do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock, asynchronous to clk |
| serData | input | 1 | Serial data in |
| serLoad | input | 1 | Load strobe; its rising edge writes a channel |
| serOut | output | 1 | Far end of the shift register, for chaining |
| codes | output | 64 | Eight 8-bit channel codes; channel 1 in bits 7:0 |

## Verification
The assertions assume that every serial pin stays at one level for at least a few system clocks between transitions. This lets each synchronized edge become exactly one one-cycle strobe. They also assume that the data pin is settled before the serial clock rises. The stimulus holds the data pin for three system clocks before each serial clock edge. It keeps each serial clock phase and each load strobe phase at four or more system clocks.

// File: rtl/serial_code_pkg.sv
package serial_code_pkg;

  // Strobes passed from the serial front end to the datapath
  typedef struct packed {
    logic shiftEn;   // one cycle per rising serial clock
    logic shiftBit;  // synchronized data bit for that shift
    logic writeEn;   // one cycle per rising load strobe
  } ctrlStrobe_t;

endpackage

// File: rtl/serial_code_ctrl.sv
module serial_code_ctrl
  import serial_code_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLoad,
  output ctrlStrobe_t strobe
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkSync;
  logic [SYNC_STAGES-1:0] dataSync;
  logic [SYNC_STAGES-1:0] loadSync;
  logic                   clkPrev;
  logic                   loadPrev;

  // Data runs through the same number of stages as the clock, so the bit
  // seen on the detected edge was on the pin when the serial clock rose.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      dataSync <= '0;
      loadSync <= '0;
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      clkSync  <= {clkSync[LAST-1:0], serClk};
      dataSync <= {dataSync[LAST-1:0], serData};
      loadSync <= {loadSync[LAST-1:0], serLoad};
      clkPrev  <= clkSync[LAST];
      loadPrev <= loadSync[LAST];
    end
  end

  always_comb begin
    strobe.shiftEn  = clkSync[LAST] & ~clkPrev;
    strobe.shiftBit = dataSync[LAST];
    strobe.writeEn  = loadSync[LAST] & ~loadPrev;
  end

  AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> !strobe.shiftEn); // R7

  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn |=> !strobe.writeEn); // R5

endmodule

// File: rtl/serial_code_datapath.sv
module serial_code_datapath
  import serial_code_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int CODE_W   = 8,
  parameter int SEL_W    = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  output logic                       serOut,
  output logic [CHANNELS*CODE_W-1:0] codes
);

  localparam int FRAME_W = CODE_W + SEL_W;

  logic [FRAME_W-1:0]  shiftReg;
  logic [CODE_W-1:0]   codeField;
  logic [SEL_W-1:0]    selVal;
  logic [CHANNELS-1:0] chanWe;
  logic                selValid;

  // Index i holds Di: the first bit sent ends up in the top place.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], strobe.shiftBit};
  end

  assign codeField = shiftReg[CODE_W-1:0];
  assign serOut    = shiftReg[FRAME_W-1];

  // The address field is read in reverse: the top bit D(FRAME_W-1) is the
  // address LSB.
  always_comb begin
    for (int b = 0; b < SEL_W; b++) selVal[b] = shiftReg[FRAME_W-1-b];
  end

  assign selValid = (selVal != '0) && (int'(selVal) <= CHANNELS);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    localparam logic [SEL_W-1:0] CH_ID = SEL_W'(c + 1);
    logic [CODE_W-1:0] codeReg;

    assign chanWe[c] = strobe.writeEn && (selVal == CH_ID);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          codeReg <= '0;
      else if (chanWe[c]) codeReg <= codeField;
    end

    assign codes[c*CODE_W +: CODE_W] = codeReg;
  end

  AST_NO_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(shiftReg)); // R7

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeEn |=> $stable(codes)); // R5

  AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeEn && !selValid) |=> $stable(codes)); // R4

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn |=> ($countones(codes ^ $past(codes)) <= CODE_W)); // R3

endmodule

// File: rtl/serial_code_bank.sv
module serial_code_bank
  import serial_code_pkg::*;
#(
  parameter int CHANNELS    = 8,
  parameter int CODE_W      = 8,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serClk,
  input  logic                       serData,
  input  logic                       serLoad,
  output logic                       serOut,
  output logic [CHANNELS*CODE_W-1:0] codes
);

  ctrlStrobe_t strobe;

  serial_code_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .serData (serData),
    .serLoad (serLoad),
    .strobe  (strobe)
  );

  serial_code_datapath #(
    .CHANNELS(CHANNELS),
    .CODE_W  (CODE_W),
    .SEL_W   (SEL_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .serOut (serOut),
    .codes  (codes)
  );

endmodule

// File: tb/serial_code_bank_tb.sv
module serial_code_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        serLoad = 1'b0;
  logic        serOut;
  logic [63:0] codes;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] expCode [1:8];

  always #2 clk = ~clk;

  serial_code_bank u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .serOut(serOut), .codes(codes)
  );

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expAll();
    logic [63:0] v;
    for (int c = 1; c <= 8; c++) v[(c-1)*8 +: 8] = expCode[c];
    return v;
  endfunction

  function automatic logic [11:0] makeWord(input logic [3:0] sel, input logic [7:0] code);
    logic [11:0] w;
    w[7:0] = code;
    w[8]  = sel[3];
    w[9]  = sel[2];
    w[10] = sel[1];
    w[11] = sel[0];
    return w;
  endfunction

  task automatic sendBit(input logic b, input int highCyc = 4);
    serData = b;
    waitCyc(3);
    serClk = 1'b1;
    waitCyc(highCyc);
    serClk = 1'b0;
    waitCyc(4);
  endtask

  task automatic sendWord(input logic [11:0] w);
    for (int i = 11; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic pulseLoad();
    serLoad = 1'b1;
    waitCyc(6);
    serLoad = 1'b0;
    waitCyc(6);
  endtask

  task automatic writeChan(input logic [3:0] sel, input logic [7:0] code);
    sendWord(makeWord(sel, code));
    pulseLoad();
    if (sel >= 1 && sel <= 8) expCode[sel] = code;
  endtask

  task automatic testReset();
    for (int c = 1; c <= 8; c++) expCode[c] = 8'h00;
    check("R1 codes", codes, 64'h0);
    check("R1 serOut", {63'h0, serOut}, 64'h0);
  endtask

  task automatic testAllChannels();
    for (int c = 1; c <= 8; c++) begin
      writeChan(4'(c), 8'(8'h11 * c + 8'h0A));
      check("R3 one channel", codes, expAll());
    end
  endtask

  task automatic testBitOrder();
    writeChan(4'd5, 8'h01);
    check("R2 lsb", {56'h0, codes[39:32]}, 64'h01);
    writeChan(4'd5, 8'h80);
    check("R2 msb", {56'h0, codes[39:32]}, 64'h80);
    writeChan(4'd1, 8'hA5);
    check("R2 pattern", codes, expAll());
  endtask

  task automatic testBadSelect();
    writeChan(4'd0, 8'hFF);
    check("R4 sel 0", codes, expAll());
    for (int s = 9; s <= 15; s++) begin
      writeChan(4'(s), 8'h3C);
      check("R4 sel high", codes, expAll());
    end
  endtask

  task automatic testLoadHeld();
    logic [11:0] w;
    writeChan(4'd2, 8'h55);
    w = makeWord(4'd2, 8'hC3);
    serLoad = 1'b1;
    waitCyc(6);
    check("R5 first write", codes, expAll());
    sendWord(w);
    waitCyc(6);
    check("R5 no write while held", codes, expAll());
    check("R5 shifted while held", {63'h0, serOut}, {63'h0, w[11]});
    serLoad = 1'b0;
    waitCyc(6);
    pulseLoad();
    expCode[2] = 8'hC3;
    check("R5 next rise writes", codes, expAll());
  endtask

  task automatic testChainOut();
    logic [11:0] w;
    w = makeWord(4'd6, 8'h4E);
    sendWord(w);
    check("R6 after word", {63'h0, serOut}, {63'h0, w[11]});
    for (int i = 10; i >= 8; i--) begin
      sendBit(1'b0);
      check("R6 shifted out", {63'h0, serOut}, {63'h0, w[i]});
    end
  endtask

  task automatic testLongHigh();
    logic [11:0] w;
    w = 12'b1010_0110_1001;
    sendWord(w);
    // One long pulse must move the register by exactly one place.
    sendBit(1'b0, 40);
    check("R7 long high one shift", {63'h0, serOut}, {63'h0, w[10]});
    serData = ~serData;
    waitCyc(20);
    check("R7 no clock no shift", {63'h0, serOut}, {63'h0, w[10]});
    check("R7 codes unchanged", codes, expAll());
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    testReset();
    testAllChannels();
    testBitOrder();
    testBadSelect();
    testLoadHeld();
    testChainOut();
    testLongHigh();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule